// File: doc/BRIEF.md
# Preemptive Fixed-Priority DMA Channel Arbiter

This block picks which of a group of DMA channels the transfer engine serves next. Each channel has a small configuration byte. The byte holds a 4-bit priority value and a preempt-enable flag. It also shows a group-level field, which is read-only and mirrors an input driven from outside the block. A mode input selects between two schemes. In fixed mode, the pending channel with the highest numeric priority wins. In rotating mode, channels are granted in round-robin order.

In fixed mode, a running channel that has its preempt-enable flag set can be set aside in favour of a higher-priority request. The suspended channel is parked in a single slot. It comes back once the preempting channel reports the end of its minor loop. A restored channel is shielded from a second preemption until it completes one read/write sequence. A preempting channel can never itself be preempted.

Any two channels that share a priority value raise a configuration error, and no new grant is made while it is raised. A per-channel error register collects error strobes from the engine, and software clears its bits by writing 1 to them.

Top module: `dma_prio_arb`

## Requirements
- R1: In fixed mode (`rr_mode`=0), when no channel is active and the configuration is valid, the requesting channel with the largest priority value becomes active on the next clock edge. `switch_pulse` is high for that one cycle.
- R2: After reset, channel i holds priority i with its preempt flag clear. No channel is active, no channel is suspended, `err_status` is all zero and `cfg_err` is low.
- R3: `cfg_err` is high whenever two channels hold the same priority value, and it goes low once all values are distinct again. While it is high, no idle-to-active grant and no preemption takes place.
- R4: `cfg_rdata` for channel `cfg_rch` is laid out as follows: bit 7 is the preempt flag, bit 6 reads 0, bits 5:4 carry `grp_level`, and bits 3:0 carry the priority. A write loads only bits 7 and 3:0, so bits 6:4 of the written data have no effect.
- R5: In fixed mode, an active channel with its preempt flag set is preempted on the next edge when another requesting channel holds a larger priority. The active channel moves to the suspend slot, the winner becomes active, and `preempting` and `switch_pulse` are raised.
- R6: When `minor_done` arrives during a preemption, the suspended channel becomes active again on the next edge. `preempting` and `susp_valid` drop, and `switch_pulse` is raised.
- R7: A restored channel cannot be preempted until `rw_done` has been seen while it is active. From the edge after that, a pending higher-priority request preempts it.
- R8: While `preempting` is high, the active channel does not change until `minor_done`, whatever the requests.
- R9: In rotating mode (`rr_mode`=1), an idle arbiter grants the first requesting channel after the most recently granted one, wrapping around from NCH-1 to 0. No preemption ever occurs in this mode.
- R10: `err_status` bit i (for i below NCH) is set by `err_strb[i]`. It is cleared by `err_clr_we` together with `err_clr[i]`=1, and a set in the same cycle wins over the clear. Bits at or above NCH always read 0.
- R11: `minor_done` on a channel that is not preempting returns the arbiter to idle on the next edge.
- R12: An active channel whose preempt flag is clear keeps running even when a higher-priority channel is requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_mode | input | 1 | 1 selects rotating arbitration, 0 selects fixed priority |
| grp_level | input | 2 | Group priority level, shown read-only in each configuration byte |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wch | input | CW | Channel being written |
| cfg_wdata | input | 8 | Write data: bit 7 is the preempt flag, bits 3:0 the priority |
| cfg_rch | input | CW | Channel being read |
| cfg_rdata | output | 8 | Configuration byte of `cfg_rch` |
| req | input | NCH | Service request per channel |
| rw_done | input | 1 | Active channel completed one read/write sequence |
| minor_done | input | 1 | Active channel completed its minor loop |
| err_strb | input | NCH | Per-channel error strobe from the engine |
| err_clr_we | input | 1 | Error clear strobe |
| err_clr | input | ERRW | Write-1-to-clear mask for `err_status` |
| act_valid | output | 1 | A channel is active |
| act_ch | output | CW | Active channel |
| switch_pulse | output | 1 | Active channel changed to a new or restored channel |
| preempting | output | 1 | The active channel is a preemptor |
| susp_valid | output | 1 | The suspend slot is occupied |
| susp_ch | output | CW | Suspended channel |
| cfg_err | output | 1 | Duplicate priority values present |
| err_status | output | ERRW | Per-channel error flags |

## Verification
The hardest state to reach is a restored channel that has a higher-priority request waiting. The arbiter must hold that request off until the restored channel reports `rw_done`, and only then preempt it. Reaching this state takes a full preempt-and-restore cycle while the third request stays asserted. A directed sequence builds this up step by step. Constrained-random traffic then mixes preemption, rotating-mode switches, priority rewrites that collide, and error strobes, all compared against a cycle-level model in the bench.

// File: rtl/dma_prio_arb.sv
`timescale 1ns/1ps
module dma_prio_arb #(
  parameter int NCH  = 16,
  parameter int ERRW = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  rr_mode,
  input  logic [1:0]                            grp_level,
  input  logic                                  cfg_we,
  input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] cfg_wch,
  input  logic [7:0]                            cfg_wdata,
  input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] cfg_rch,
  output logic [7:0]                            cfg_rdata,
  input  logic [NCH-1:0]                        req,
  input  logic                                  rw_done,
  input  logic                                  minor_done,
  input  logic [NCH-1:0]                        err_strb,
  input  logic                                  err_clr_we,
  input  logic [ERRW-1:0]                       err_clr,
  output logic                                  act_valid,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] act_ch,
  output logic                                  switch_pulse,
  output logic                                  preempting,
  output logic                                  susp_valid,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] susp_ch,
  output logic                                  cfg_err,
  output logic [ERRW-1:0]                       err_status
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PW = 4;

  logic [PW-1:0] pri [NCH];
  logic [NCH-1:0] ecp;
  logic [CW-1:0] last;
  logic hold;

  // configuration bytes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) pri[i] <= PW'(i);
      ecp <= '0;
    end else if (cfg_we && int'(cfg_wch) < NCH) begin
      pri[cfg_wch] <= cfg_wdata[PW-1:0];
      ecp[cfg_wch] <= cfg_wdata[7];
    end
  end

  assign cfg_rdata = {ecp[cfg_rch], 1'b0, grp_level, pri[cfg_rch]};

  // duplicate priority detection
  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < NCH; i++)
      for (int j = i + 1; j < NCH; j++)
        if (pri[i] == pri[j]) dup = 1'b1;
  end
  assign cfg_err = dup;

  // fixed-priority winner
  logic          fx_any;
  logic [CW-1:0] fx_ch;
  logic [PW-1:0] fx_pri;
  always_comb begin
    fx_any = 1'b0;
    fx_ch  = '0;
    fx_pri = '0;
    for (int i = 0; i < NCH; i++)
      if (req[i] && (!fx_any || pri[i] > fx_pri)) begin
        fx_any = 1'b1;
        fx_ch  = CW'(i);
        fx_pri = pri[i];
      end
  end

  // rotating winner
  logic          rr_any;
  logic [CW-1:0] rr_ch;
  always_comb begin
    rr_any = 1'b0;
    rr_ch  = '0;
    for (int k = NCH; k >= 1; k--) begin
      if (req[(int'(last) + k) % NCH]) begin
        rr_any = 1'b1;
        rr_ch  = CW'((int'(last) + k) % NCH);
      end
    end
  end

  wire          win_any = rr_mode ? rr_any : fx_any;
  wire [CW-1:0] win_ch  = rr_mode ? rr_ch  : fx_ch;
  wire can_pre = !rr_mode && act_valid && !preempting && !hold && ecp[act_ch]
                 && fx_any && (fx_pri > pri[act_ch]) && !dup;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_valid    <= 1'b0;
      act_ch       <= '0;
      switch_pulse <= 1'b0;
      preempting   <= 1'b0;
      susp_valid   <= 1'b0;
      susp_ch      <= '0;
      hold         <= 1'b0;
      last         <= CW'(NCH - 1);
    end else begin
      switch_pulse <= 1'b0;
      if (act_valid && minor_done) begin
        if (preempting) begin
          act_ch       <= susp_ch;
          susp_valid   <= 1'b0;
          preempting   <= 1'b0;
          hold         <= 1'b1;
          switch_pulse <= 1'b1;
        end else begin
          act_valid <= 1'b0;
          hold      <= 1'b0;
        end
      end else if (act_valid) begin
        if (can_pre) begin
          susp_ch      <= act_ch;
          susp_valid   <= 1'b1;
          act_ch       <= fx_ch;
          preempting   <= 1'b1;
          last         <= fx_ch;
          switch_pulse <= 1'b1;
        end else if (rw_done) begin
          hold <= 1'b0;
        end
      end else if (win_any && !dup) begin
        act_valid    <= 1'b1;
        act_ch       <= win_ch;
        last         <= win_ch;
        hold         <= 1'b0;
        switch_pulse <= 1'b1;
      end
    end
  end

  // error status
  logic [ERRW-1:0] err_q;
  for (genvar g = 0; g < ERRW; g++) begin : g_err
    if (g < NCH) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n) err_q[g] <= 1'b0;
        else err_q[g] <= err_strb[g] | (err_q[g] & ~(err_clr_we & err_clr[g]));
      end
    end else begin : g_tie
      assign err_q[g] = 1'b0;
    end
  end
  assign err_status = err_q;

  assert_switch_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> act_valid);
  assert_cfg_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !act_valid) |=> !act_valid);
  assert_susp_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    preempting |-> susp_valid);
  assert_restore_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && act_valid && !minor_done && !rw_done) |=> (act_ch == $past(act_ch)));
  assert_no_nest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (preempting && !minor_done) |=> (preempting && act_ch == $past(act_ch)));
  assert_rr_no_preempt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_mode && !preempting) |=> !preempting);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_strb != '0) |=> ((err_status[NCH-1:0] & $past(err_strb)) == $past(err_strb)));
endmodule

// File: tb/dma_prio_arb_tb.sv
`timescale 1ns/1ps
module dma_prio_arb_tb;
  localparam int NCH = 16;
  localparam int ERRW = 32;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0, rr_mode = 0;
  logic [1:0] grp_level = 0;
  logic cfg_we = 0;
  logic [CW-1:0] cfg_wch = 0, cfg_rch = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [NCH-1:0] req = 0, err_strb = 0;
  logic rw_done = 0, minor_done = 0, err_clr_we = 0;
  logic [ERRW-1:0] err_clr = 0, err_status;
  logic act_valid, switch_pulse, preempting, susp_valid, cfg_err;
  logic [CW-1:0] act_ch, susp_ch;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_prio_arb #(.NCH(NCH), .ERRW(ERRW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .grp_level(grp_level),
    .cfg_we(cfg_we), .cfg_wch(cfg_wch), .cfg_wdata(cfg_wdata),
    .cfg_rch(cfg_rch), .cfg_rdata(cfg_rdata), .req(req),
    .rw_done(rw_done), .minor_done(minor_done), .err_strb(err_strb),
    .err_clr_we(err_clr_we), .err_clr(err_clr), .act_valid(act_valid),
    .act_ch(act_ch), .switch_pulse(switch_pulse), .preempting(preempting),
    .susp_valid(susp_valid), .susp_ch(susp_ch), .cfg_err(cfg_err),
    .err_status(err_status));

  // reference model
  logic [3:0] m_pri [NCH];
  logic [NCH-1:0] m_ecp;
  logic m_av, m_sw, m_pre, m_sv, m_hold;
  logic [CW-1:0] m_act, m_susp, m_last;
  logic [ERRW-1:0] m_err;

  function automatic bit m_dup();
    for (int i = 0; i < NCH; i++)
      for (int j = i + 1; j < NCH; j++)
        if (m_pri[i] == m_pri[j]) return 1;
    return 0;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < NCH; i++) m_pri[i] = 4'(i);
    m_ecp = 0; m_av = 0; m_sw = 0; m_pre = 0; m_sv = 0; m_hold = 0;
    m_act = 0; m_susp = 0; m_last = CW'(NCH - 1); m_err = 0;
  endtask

  task automatic m_step();
    bit dup, fa, ra, wa, cp;
    logic [CW-1:0] fc, rc, wc;
    logic [3:0] fp;
    dup = m_dup();
    fa = 0; fc = 0; fp = 0;
    for (int i = 0; i < NCH; i++)
      if (req[i] && (!fa || m_pri[i] > fp)) begin fa = 1; fc = CW'(i); fp = m_pri[i]; end
    ra = 0; rc = 0;
    for (int k = 1; k <= NCH; k++)
      if (!ra && req[(int'(m_last) + k) % NCH]) begin ra = 1; rc = CW'((int'(m_last) + k) % NCH); end
    wa = rr_mode ? ra : fa;
    wc = rr_mode ? rc : fc;
    cp = !rr_mode && m_av && !m_pre && !m_hold && m_ecp[m_act] && fa && fp > m_pri[m_act] && !dup;
    m_sw = 0;
    if (m_av && minor_done) begin
      if (m_pre) begin m_act = m_susp; m_sv = 0; m_pre = 0; m_hold = 1; m_sw = 1; end
      else begin m_av = 0; m_hold = 0; end
    end else if (m_av) begin
      if (cp) begin m_susp = m_act; m_sv = 1; m_act = fc; m_pre = 1; m_last = fc; m_sw = 1; end
      else if (rw_done) m_hold = 0;
    end else if (wa && !dup) begin
      m_av = 1; m_act = wc; m_last = wc; m_hold = 0; m_sw = 1;
    end
    if (cfg_we) begin m_pri[cfg_wch] = cfg_wdata[3:0]; m_ecp[cfg_wch] = cfg_wdata[7]; end
    for (int i = 0; i < NCH; i++)
      m_err[i] = err_strb[i] | (m_err[i] & ~(err_clr_we & err_clr[i]));
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk(act_valid, m_av, "R1 model act_valid");
    if (m_av) chk(act_ch, m_act, "R1 model act_ch");
    chk(switch_pulse, m_sw, "R1 model switch_pulse");
    chk(preempting, m_pre, "R5 model preempting");
    chk(susp_valid, m_sv, "R5 model susp_valid");
    if (m_sv) chk(susp_ch, m_susp, "R5 model susp_ch");
    chk(cfg_err, m_dup(), "R3 model cfg_err");
    chk(err_status, m_err, "R10 model err_status");
    chk(cfg_rdata, {m_ecp[cfg_rch], 1'b0, grp_level, m_pri[cfg_rch]}, "R4 model cfg_rdata");
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    cmp_all();
    minor_done = 0; rw_done = 0; cfg_we = 0; err_strb = 0; err_clr_we = 0;
  endtask

  task automatic wr(input int ch, input logic [7:0] d);
    cfg_we = 1; cfg_wch = CW'(ch); cfg_wdata = d;
    cyc();
  endtask

  initial begin
    void'($urandom(32'h5eed_0d1a));
    repeat (3) @(negedge clk);
    cfg_rch = 5;
    #0;
    chk(act_valid, 0, "R2 reset act_valid");
    chk(err_status, 0, "R2 reset err_status");
    chk(cfg_err, 0, "R2 reset cfg_err");
    chk(cfg_rdata, 8'h05, "R2 reset cfg byte ch5");
    rst_n = 1;
    cyc();

    // R1 / R5 / R8 / R6 / R7
    wr(2, 8'h82);
    req = 16'h0004; cyc();
    chk(act_ch, 2, "R1 grant ch2"); chk(switch_pulse, 1, "R1 switch pulse");
    req = 16'h0204; cyc();
    chk(act_ch, 9, "R5 preempt to ch9"); chk(susp_ch, 2, "R5 suspended ch2");
    chk(preempting, 1, "R5 preempting flag");
    req = 16'h8204; cyc();
    chk(act_ch, 9, "R8 no nested preempt");
    minor_done = 1; req = 16'h8004; cyc();
    chk(act_ch, 2, "R6 restore ch2"); chk(preempting, 0, "R6 preempting drops");
    chk(switch_pulse, 1, "R6 switch on restore");
    cyc();
    chk(act_ch, 2, "R7 restored held before rw_done");
    rw_done = 1; cyc();
    chk(act_ch, 2, "R7 held on rw_done edge");
    cyc();
    chk(act_ch, 15, "R7 preempt after rw_done");
    minor_done = 1; req = 16'h0004; cyc();
    chk(act_ch, 2, "R6 second restore");
    minor_done = 1; req = 0; cyc();
    chk(act_valid, 0, "R11 idle after minor_done");

    // R12
    req = 16'h0008; cyc();
    chk(act_ch, 3, "R12 grant ch3");
    req = 16'h0408; cyc();
    chk(act_ch, 3, "R12 no preempt without flag");
    minor_done = 1; req = 16'h0400; cyc();
    chk(act_valid, 0, "R11 idle");
    cyc();
    chk(act_ch, 10, "R1 grant ch10");
    minor_done = 1; req = 0; cyc();

    // R3
    wr(5, 8'h07);
    chk(cfg_err, 1, "R3 duplicate flagged");
    req = 16'h0001; cyc(); cyc();
    chk(act_valid, 0, "R3 no grant on error");
    wr(5, 8'h05);
    chk(cfg_err, 0, "R3 error clears");
    cyc();
    chk(act_ch, 0, "R3 grant resumes");
    minor_done = 1; req = 0; cyc();

    // R9
    rr_mode = 1; req = 16'h1012; cyc();
    chk(act_ch, 1, "R9 rotate to ch1");
    minor_done = 1; cyc(); cyc();
    chk(act_ch, 4, "R9 rotate to ch4");
    minor_done = 1; cyc(); cyc();
    chk(act_ch, 12, "R9 rotate to ch12");
    minor_done = 1; cyc(); cyc();
    chk(act_ch, 1, "R9 wrap to ch1");
    minor_done = 1; req = 16'h8004; cyc(); cyc();
    chk(act_ch, 2, "R9 next after ch1");
    cyc();
    chk(act_ch, 2, "R9 no preempt in rotating mode");
    chk(preempting, 0, "R9 preempting low");
    minor_done = 1; req = 0; cyc();
    rr_mode = 0;

    // R4
    grp_level = 3; cfg_rch = 2; cyc();
    chk(cfg_rdata, 8'hB2, "R4 read layout");
    wr(2, 8'h72);
    chk(cfg_rdata, 8'h32, "R4 group field not writable");

    // R10
    err_strb = 16'h0021; cyc();
    chk(err_status, 32'h21, "R10 strobes set");
    err_clr_we = 1; err_clr = 32'hFFFF_0021; err_strb = 16'h0020; cyc();
    chk(err_status, 32'h20, "R10 set wins over clear");
    err_clr_we = 1; err_clr = 32'h20; cyc();
    chk(err_status, 0, "R10 write one clears");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      req = NCH'($urandom) & NCH'($urandom);
      minor_done = ($urandom % 4) == 0;
      rw_done = ($urandom % 3) == 0;
      if (($urandom % 200) == 0) rr_mode = ~rr_mode;
      if (($urandom % 24) == 0) begin
        cfg_we = 1; cfg_wch = CW'($urandom); cfg_wdata = 8'($urandom);
      end
      if (($urandom % 8) == 0) err_strb = NCH'(1) << ($urandom % NCH);
      if (($urandom % 8) == 0) begin err_clr_we = 1; err_clr = $urandom; end
      cfg_rch = CW'($urandom);
      grp_level = 2'($urandom);
      cyc();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule